// File: doc/BRIEF.md
# CPU Idle and Stop Mode Controller

This block holds the two mode-select bits of a small microcontroller's power control register and turns them into clock-gating enables. Bit 0 selects a light sleep ("idle") and bit 1 a deep sleep ("stop"). A write to the register only arms the request. The mode change happens when the core signals that the writing instruction has retired. In idle only the CPU clock is gated: peripherals and oscillators keep running, and any unmasked interrupt request brings the core back. In stop every clock, oscillators included, is held off, and interrupts are ignored. Only a reset event brings the core back.

Four reset sources are watched: an external reset pin, a comparator reset, an external convert-start reset and a missing-clock detector. The detector counts ticks of a separate low-speed reference while the block is in stop. If it is enabled it forces a reset after a parameterised number of ticks. Every reset event clears both mode bits and sends a reset pulse to the core, so the core restarts at address zero. It also latches a cause register showing which sources fired.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After `rst_n` is released, `mode_q` is 0, `rst_cause` is 0, `sys_rst` is 0, and `cpu_clk_en`, `per_clk_en` and `osc_en` are all 1.
- R2: While the core runs, a write stores wr_data bit 0 as the idle request (`mode_q` bit 0) and wr_data bit 1 as the stop request (`mode_q` bit 1). If both are 1, only the stop bit is kept (`mode_q` = 2'b10).
- R3: A stored or freshly written request changes no clock enable until `instr_retire` is sampled high. The enables change on the clock edge after that one.
- R4: In idle, `cpu_clk_en` is 0 while `per_clk_en` and `osc_en` stay 1.
- R5: In idle, a request on any `irq_req` line whose `irq_en` bit is 1 clears `mode_q` bit 0 and raises `cpu_clk_en` on the next edge. Requests whose enable bit is 0 leave the block in idle.
- R6: In stop, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0, and interrupt requests, enabled or not, leave the block in stop.
- R7: Any reset source high at an edge, in any state, gives `sys_rst` = 1, `mode_q` = 0 and all enables 1 after that edge. `sys_rst` returns to 0 one edge after the sources drop.
- R8: On a reset event `rst_cause` captures all sources that fired together. The bit positions are: bit 0 the pin, bit 1 the missing-clock detector, bit 2 the comparator, bit 3 the convert-start input. It keeps that value until the next event.
- R9: With `mcd_en` = 1 in stop, the MCD_LIMIT-th `ref_tick` counted in stop triggers a reset recorded as cause bit 1. With `mcd_en` = 0 no timeout ever occurs.
- R10: When an enabled interrupt and a reset source arrive in the same cycle during idle, the reset wins: `sys_rst` pulses and the cause is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low power-on reset of the block |
| wr_en | input | 1 | Write strobe for the mode register |
| wr_data | input | CTRL_W | Write data; bit 0 idle request, bit 1 stop request |
| instr_retire | input | 1 | Core has completed the current instruction |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| rst_pin_req | input | 1 | External reset pin event |
| rst_cmp_req | input | 1 | Comparator reset event |
| rst_cnv_req | input | 1 | External convert-start reset event |
| mcd_en | input | 1 | Missing-clock detector enable |
| ref_tick | input | 1 | Tick from the low-speed reference timebase |
| cpu_clk_en | output | 1 | CPU and program-memory clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator run enable |
| mode_q | output | 2 | Mode register read-back |
| sys_rst | output | 1 | Reset pulse to the core |
| rst_cause | output | 4 | Sources of the latest reset event |

## Verification
Two same-cycle collisions matter most. The first is a mode-register write together with the retire strobe. The second is an enabled interrupt together with a reset source while in idle. The bench drives the write and the retire in one cycle and expects the sleep state on the very next edge. It also drives an interrupt and a comparator reset in one idle cycle. A wake by interrupt would leave `sys_rst` low and `rst_cause` unchanged. A winning reset raises `sys_rst` and writes 4'b0100 into the cause register, so the outcome can be read at the ports.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;
   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_IDLE = 2'd1,
      PM_STOP = 2'd2
   } pm_state_e;

   localparam int MODE_W    = 2;
   localparam int SEL_IDLE  = 0;
   localparam int SEL_STOP  = 1;

   localparam int CAUSE_W   = 4;
   localparam int CAUSE_PIN = 0;
   localparam int CAUSE_MCD = 1;
   localparam int CAUSE_CMP = 2;
   localparam int CAUSE_CNV = 3;
endpackage

// File: rtl/pwrmode_modereg.sv
module pwrmode_modereg
   import pwrmode_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_sel,
   input  logic              running,
   input  logic              wake_irq,
   input  logic              core_rst,
   output logic [MODE_W-1:0] mode_q,
   output logic [MODE_W-1:0] mode_nxt
);
   logic [MODE_W-1:0] wr_clean;

   // stop outranks idle when both are requested together
   always_comb begin
      wr_clean = '0;
      if (wr_sel[SEL_STOP])
         wr_clean[SEL_STOP] = 1'b1;
      else
         wr_clean[SEL_IDLE] = wr_sel[SEL_IDLE];
   end

   // the CPU can only write while its clock is running
   assign mode_nxt = (wr_en && running) ? wr_clean : mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= '0;
      else if (core_rst)
         mode_q <= '0;
      else if (wake_irq)
         mode_q <= mode_q & ~(MODE_W'(1) << SEL_IDLE);
      else
         mode_q <= mode_nxt;
   end
endmodule

// File: rtl/pwrmode_fsm.sv
module pwrmode_fsm
   import pwrmode_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_nxt,
   input  logic              instr_retire,
   input  logic              irq_hit,
   input  logic              core_rst,
   output pm_state_e         state_q,
   output logic              wake_irq
);
   pm_state_e state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PM_RUN: begin
            if (instr_retire && mode_nxt[SEL_STOP])
               state_d = PM_STOP;
            else if (instr_retire && mode_nxt[SEL_IDLE])
               state_d = PM_IDLE;
         end
         PM_IDLE: begin
            if (irq_hit)
               state_d = PM_RUN;
         end
         PM_STOP: state_d = PM_STOP;
         default: state_d = PM_RUN;
      endcase
      if (core_rst)
         state_d = PM_RUN;
   end

   assign wake_irq = (state_q == PM_IDLE) && irq_hit && !core_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= PM_RUN;
      else
         state_q <= state_d;
   end
endmodule

// File: rtl/pwrmode_mcd.sv
module pwrmode_mcd #(
   parameter bit MCD_PRESENT = 1'b1,
   parameter int MCD_LIMIT   = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic ref_tick,
   output logic timeout
);
   localparam int CNT_W = (MCD_LIMIT > 1) ? $clog2(MCD_LIMIT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(MCD_LIMIT - 1);

   generate
      if (MCD_PRESENT) begin : g_det
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!armed)
               cnt_q <= '0;
            else if (ref_tick)
               cnt_q <= cnt_q + CNT_W'(1);
         end

         assign timeout = armed && ref_tick && (cnt_q == LAST);
      end else begin : g_none
         logic unused_mcd;
         assign unused_mcd = ^{clk, rst_n, armed, ref_tick};
         assign timeout    = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pwrmode_rstcause.sv
module pwrmode_rstcause
   import pwrmode_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               src_pin,
   input  logic               src_mcd,
   input  logic               src_cmp,
   input  logic               src_cnv,
   output logic               core_rst,
   output logic               sys_rst_q,
   output logic [CAUSE_W-1:0] cause_q
);
   logic [CAUSE_W-1:0] src_vec;

   always_comb begin
      src_vec            = '0;
      src_vec[CAUSE_PIN] = src_pin;
      src_vec[CAUSE_MCD] = src_mcd;
      src_vec[CAUSE_CMP] = src_cmp;
      src_vec[CAUSE_CNV] = src_cnv;
   end

   assign core_rst = |src_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys_rst_q <= 1'b0;
         cause_q   <= '0;
      end else begin
         sys_rst_q <= core_rst;
         if (core_rst)
            cause_q <= src_vec;
      end
   end
endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
   import pwrmode_pkg::*;
#(
   parameter int N_IRQ       = 4,
   parameter int CTRL_W      = 8,
   parameter bit MCD_PRESENT = 1'b1,
   parameter int MCD_LIMIT   = 100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [CTRL_W-1:0]  wr_data,
   input  logic               instr_retire,
   input  logic [N_IRQ-1:0]   irq_req,
   input  logic [N_IRQ-1:0]   irq_en,
   input  logic               rst_pin_req,
   input  logic               rst_cmp_req,
   input  logic               rst_cnv_req,
   input  logic               mcd_en,
   input  logic               ref_tick,
   output logic               cpu_clk_en,
   output logic               per_clk_en,
   output logic               osc_en,
   output logic [MODE_W-1:0]  mode_q,
   output logic               sys_rst,
   output logic [CAUSE_W-1:0] rst_cause
);
   generate
      if (N_IRQ < 1) begin : g_bad_irq
         $error("pwrmode_ctrl: N_IRQ must be at least 1");
      end
      if (CTRL_W < MODE_W) begin : g_bad_ctrl
         $error("pwrmode_ctrl: CTRL_W must hold both mode bits");
      end
      if (MCD_LIMIT < 2) begin : g_bad_lim
         $error("pwrmode_ctrl: MCD_LIMIT must be at least 2");
      end
   endgenerate

   pm_state_e         state_q;
   logic [MODE_W-1:0] mode_nxt;
   logic              wake_irq;
   logic              core_rst;
   logic              mcd_fire;
   logic              irq_hit;
   logic [N_IRQ-1:0]  irq_live;

   generate
      for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
         assign irq_live[i] = irq_req[i] & irq_en[i];
      end
      if (CTRL_W > MODE_W) begin : g_ctrl_hi
         logic unused_ctrl_hi;
         assign unused_ctrl_hi = ^wr_data[CTRL_W-1:MODE_W];
      end
   endgenerate

   assign irq_hit = |irq_live;

   pwrmode_modereg u_modereg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_data[MODE_W-1:0]),
      .running  (state_q == PM_RUN),
      .wake_irq (wake_irq),
      .core_rst (core_rst),
      .mode_q   (mode_q),
      .mode_nxt (mode_nxt)
   );

   pwrmode_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_nxt     (mode_nxt),
      .instr_retire (instr_retire),
      .irq_hit      (irq_hit),
      .core_rst     (core_rst),
      .state_q      (state_q),
      .wake_irq     (wake_irq)
   );

   pwrmode_mcd #(
      .MCD_PRESENT (MCD_PRESENT),
      .MCD_LIMIT   (MCD_LIMIT)
   ) u_mcd (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed    ((state_q == PM_STOP) && mcd_en),
      .ref_tick (ref_tick),
      .timeout  (mcd_fire)
   );

   pwrmode_rstcause u_rstcause (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_pin   (rst_pin_req),
      .src_mcd   (mcd_fire),
      .src_cmp   (rst_cmp_req),
      .src_cnv   (rst_cnv_req),
      .core_rst  (core_rst),
      .sys_rst_q (sys_rst),
      .cause_q   (rst_cause)
   );

   assign cpu_clk_en = (state_q == PM_RUN);
   assign per_clk_en = (state_q != PM_STOP);
   assign osc_en     = (state_q != PM_STOP);
endmodule

// File: rtl/pwrmode_ctrl_chk.sv
module pwrmode_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       instr_retire,
   input logic       irq_hit,
   input logic       rst_pin_req,
   input logic       rst_cmp_req,
   input logic       rst_cnv_req,
   input logic       mcd_fire,
   input logic       cpu_clk_en,
   input logic       per_clk_en,
   input logic       osc_en,
   input logic [1:0] mode_q,
   input logic       sys_rst,
   input logic [3:0] rst_cause
);
   logic any_src;
   assign any_src = rst_pin_req | rst_cmp_req | rst_cnv_req | mcd_fire;

   assert_mode_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mode_q));

   assert_entry_after_retire_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_clk_en) |-> $past(instr_retire));

   assert_idle_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_clk_en && osc_en && irq_hit && !any_src) |=> (cpu_clk_en && !mode_q[0] && !sys_rst));

   assert_stop_all_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |-> (!cpu_clk_en && !per_clk_en));

   assert_stop_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en && !any_src) |=> !osc_en);

   assert_reset_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
      any_src |=> (sys_rst && mode_q == 2'b00 && cpu_clk_en && osc_en));

   assert_cause_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      any_src |=> (rst_cause == $past({rst_cnv_req, rst_cmp_req, mcd_fire, rst_pin_req})));
endmodule

bind pwrmode_ctrl pwrmode_ctrl_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .instr_retire (instr_retire),
   .irq_hit      (irq_hit),
   .rst_pin_req  (rst_pin_req),
   .rst_cmp_req  (rst_cmp_req),
   .rst_cnv_req  (rst_cnv_req),
   .mcd_fire     (mcd_fire),
   .cpu_clk_en   (cpu_clk_en),
   .per_clk_en   (per_clk_en),
   .osc_en       (osc_en),
   .mode_q       (mode_q),
   .sys_rst      (sys_rst),
   .rst_cause    (rst_cause)
);

// File: tb/pwrmode_ctrl_test.sv
module pwrmode_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NI  = 4;
   localparam int LIM = 100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_data = '0;
   logic          instr_retire = 1'b0;
   logic [NI-1:0] irq_req = '0;
   logic [NI-1:0] irq_en = '0;
   logic          rst_pin_req = 1'b0;
   logic          rst_cmp_req = 1'b0;
   logic          rst_cnv_req = 1'b0;
   logic          mcd_en = 1'b0;
   logic          ref_tick = 1'b0;
   logic          cpu_clk_en, per_clk_en, osc_en, sys_rst;
   logic [1:0]    mode_q;
   logic [3:0]    rst_cause;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwrmode_ctrl #(.N_IRQ(NI), .CTRL_W(8), .MCD_PRESENT(1'b1), .MCD_LIMIT(LIM)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .instr_retire(instr_retire), .irq_req(irq_req), .irq_en(irq_en),
      .rst_pin_req(rst_pin_req), .rst_cmp_req(rst_cmp_req), .rst_cnv_req(rst_cnv_req),
      .mcd_en(mcd_en), .ref_tick(ref_tick),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
      .mode_q(mode_q), .sys_rst(sys_rst), .rst_cause(rst_cause)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // enables packed as {cpu,per,osc}
   function automatic logic [7:0] ens();
      return {5'b0, cpu_clk_en, per_clk_en, osc_en};
   endfunction

   task automatic enter_mode(input logic [7:0] val);
      wr_en = 1'b1; wr_data = val; instr_retire = 1'b1;
      step();
      wr_en = 1'b0; wr_data = '0; instr_retire = 1'b0;
   endtask

   task automatic pulse_pin();
      rst_pin_req = 1'b1; step(); rst_pin_req = 1'b0; step();
   endtask

   task automatic t_reset_state();
      chk("R1 mode", {6'b0, mode_q}, 8'h0);
      chk("R1 cause", {4'b0, rst_cause}, 8'h0);
      chk("R1 sys_rst", {7'b0, sys_rst}, 8'h0);
      chk("R1 enables", ens(), 8'h7);
   endtask

   task automatic t_idle_cycle();
      wr_en = 1'b1; wr_data = 8'h01;
      step();
      wr_en = 1'b0; wr_data = '0;
      chk("R2 idle bit stored", {6'b0, mode_q}, 8'h1);
      chk("R3 no gating before retire", ens(), 8'h7);
      step();
      chk("R3 still running without retire", ens(), 8'h7);
      instr_retire = 1'b1; step(); instr_retire = 1'b0;
      chk("R4 idle enables", ens(), 8'h3);
      irq_req = 4'b0110; irq_en = 4'b1001;
      step(); step();
      chk("R5 masked irq keeps idle", ens(), 8'h3);
      chk("R5 masked irq keeps bit", {6'b0, mode_q}, 8'h1);
      irq_en = 4'b0100;
      step();
      irq_req = '0; irq_en = '0;
      chk("R5 wake enables", ens(), 8'h7);
      chk("R5 wake clears idle bit", {6'b0, mode_q}, 8'h0);
      chk("R5 wake is not a reset", {7'b0, sys_rst}, 8'h0);
   endtask

   task automatic t_stop_priority();
      wr_en = 1'b1; wr_data = 8'h03;
      step();
      wr_en = 1'b0; wr_data = '0;
      chk("R2 both bits keep stop only", {6'b0, mode_q}, 8'h2);
      chk("R3 write alone no gating", ens(), 8'h7);
      instr_retire = 1'b1; step(); instr_retire = 1'b0;
      chk("R6 stop enables", ens(), 8'h0);
      irq_req = '1; irq_en = '1;
      step(); step(); step();
      irq_req = '0; irq_en = '0;
      chk("R6 irq ignored in stop", ens(), 8'h0);
      chk("R6 stop bit held", {6'b0, mode_q}, 8'h2);
   endtask

   task automatic t_stop_exit(input int which, input logic [3:0] exp_cause, input string tag);
      enter_mode(8'h02);
      chk({tag, " in stop"}, ens(), 8'h0);
      if (which == 0) rst_pin_req = 1'b1;
      if (which == 2) rst_cmp_req = 1'b1;
      if (which == 3) rst_cnv_req = 1'b1;
      step();
      rst_pin_req = 1'b0; rst_cmp_req = 1'b0; rst_cnv_req = 1'b0;
      chk({tag, " R7 sys_rst"}, {7'b0, sys_rst}, 8'h1);
      chk({tag, " R7 enables"}, ens(), 8'h7);
      chk({tag, " R7 mode cleared"}, {6'b0, mode_q}, 8'h0);
      chk({tag, " R8 cause"}, {4'b0, rst_cause}, {4'b0, exp_cause});
      step();
      chk({tag, " R7 sys_rst drops"}, {7'b0, sys_rst}, 8'h0);
      chk({tag, " R8 cause held"}, {4'b0, rst_cause}, {4'b0, exp_cause});
   endtask

   task automatic t_mcd_timeout();
      mcd_en = 1'b1; ref_tick = 1'b1;
      enter_mode(8'h02);
      chk("R9 stopped", ens(), 8'h0);
      repeat (LIM - 1) step();
      chk("R9 no early timeout", {7'b0, sys_rst}, 8'h0);
      chk("R9 still stopped", ens(), 8'h0);
      step();
      chk("R9 timeout reset", {7'b0, sys_rst}, 8'h1);
      chk("R9 cause bit 1", {4'b0, rst_cause}, 8'h2);
      chk("R9 running again", ens(), 8'h7);
      mcd_en = 1'b0; ref_tick = 1'b0;
      step();
   endtask

   task automatic t_mcd_disabled();
      mcd_en = 1'b0; ref_tick = 1'b1;
      enter_mode(8'h02);
      repeat (LIM + 10) step();
      chk("R9 disabled no reset", {7'b0, sys_rst}, 8'h0);
      chk("R9 disabled stays stopped", ens(), 8'h0);
      ref_tick = 1'b0;
      pulse_pin();
      chk("R9 exit by pin", ens(), 8'h7);
   endtask

   task automatic t_collide();
      enter_mode(8'h01);
      chk("R10 in idle", ens(), 8'h3);
      irq_req = 4'b0001; irq_en = 4'b0001; rst_cmp_req = 1'b1;
      step();
      irq_req = '0; irq_en = '0; rst_cmp_req = 1'b0;
      chk("R10 reset wins pulse", {7'b0, sys_rst}, 8'h1);
      chk("R10 cause comparator", {4'b0, rst_cause}, 8'h4);
      chk("R10 running", ens(), 8'h7);
      step();
      // two sources together, from run state
      rst_pin_req = 1'b1; rst_cnv_req = 1'b1;
      step();
      rst_pin_req = 1'b0; rst_cnv_req = 1'b0;
      chk("R8 two sources", {4'b0, rst_cause}, 8'h9);
      chk("R7 reset from run", {7'b0, sys_rst}, 8'h1);
      step();
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset_state();
      t_idle_cycle();
      t_stop_priority();
      pulse_pin();
      t_stop_exit(0, 4'b0001, "pin");
      t_stop_exit(2, 4'b0100, "cmp");
      t_stop_exit(3, 4'b1000, "cnv");
      t_mcd_timeout();
      t_mcd_disabled();
      t_collide();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule